// File: doc/BRIEF.md
# Programmed Sweep Auto-Start Scheduler

This block divides a fast reference clock down to a 100 kHz pulse and then to a once-per-second tick. The tick counts a four-digit BCD clock (minutes tens, minutes units, seconds tens, seconds units) downwards. Each time the countdown lands on a five-minute mark, the scheduler looks at one program switch from a bank. The switches are visited in turn, and the visit pointer wraps after the last one.

If the visited switch is on, a request flag is set and a single-cycle auto-start pulse goes to the sweep generator. The flag stays set until the sweep generator reports the end of its sweep. While the flag is set, further enabled switches are passed over without a pulse. Two operator inputs act on the clock. An advance input steps the minute digits, and a clear input zeroes the whole clock. Only the rising edge of each input has an effect.

Top module: `sweep_autostart_sched`

## Requirements
- R1: `tap_100k_o` is high for exactly one clock cycle in every REF_DIV cycles. It is first high in the REF_DIV-th cycle after reset is released.
- R2: `tap_1hz_o` is high for one cycle once every TICK_DIV pulses of `tap_100k_o`, and always in a cycle where `tap_100k_o` is also high.
- R3: `clock_bcd_o` packs four BCD digits: minutes tens in [15:12], minutes units in [11:8], seconds tens in [7:4] and seconds units in [3:0]. On each 1 Hz tick the clock counts down by one second. A units digit wraps from 0 to 9, a tens digit wraps from 0 to 5, and each wrap borrows from the next digit up, so 00:00 becomes 59:59. The value shown one cycle after the tick is the new value.
- R4: A rising edge on `advance_i` lowers the minutes by one. The seconds are not changed, and minutes 00 become 59.
- R5: A rising edge on `clock_clear_i` sets the clock to 00:00. When events fall in the same cycle, clear wins over advance and advance wins over the tick; the losing events are dropped. Holding either input high has no effect after its first cycle.
- R6: A five-minute mark is a 1 Hz tick whose new value has seconds 00 and a minutes units digit of 0 or 5. Advance and clear never create a mark. At a mark the switch selected by `scan_idx_o` is examined, and `scan_idx_o` then moves to the next switch, wrapping from NUM_SWITCHES-1 to 0.
- R7: When the examined switch is on and `request_o` is low, `autostart_o` is high for exactly one cycle, in the cycle after the mark.
- R8: `request_o` goes high in the same cycle as the auto-start pulse and stays high. While it is high, marks at enabled switches produce no pulse.
- R9: `sweep_end_i` high clears `request_o` on the next edge. If it is high in the same cycle as a mark at an enabled switch, no pulse is produced and the request stays low.
- R10: While `rst_n` is low, the clock reads 00:00, `scan_idx_o` is 0, and `request_o`, `autostart_o` and both taps are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance_i | input | 1 | Minute-advance request, acts on its rising edge |
| clock_clear_i | input | 1 | Clock clear request, acts on its rising edge |
| sweep_end_i | input | 1 | End of sweep, clears the request |
| prog_sw_i | input | NUM_SWITCHES | Program switch bank, bit n is switch n |
| tap_100k_o | output | 1 | 100 kHz pulse tap |
| tap_1hz_o | output | 1 | 1 Hz pulse tap |
| clock_bcd_o | output | 16 | Countdown clock, four BCD digits |
| scan_idx_o | output | IDX_W | Switch to examine at the next mark |
| request_o | output | 1 | Auto-start request flag |
| autostart_o | output | 1 | One-cycle auto-start pulse |

## Verification
The hardest cases to reach are at the five-minute marks. To see the held request pass over an enabled switch, two marks with enabled switches must come one after another with no end of sweep between them. To see the clear-over-pulse case, the end of sweep must be high during a mark. Marks are 300 ticks apart, so the bench shrinks both divider parameters until a mark arrives every few thousand cycles. It then holds `sweep_end_i` high across a whole mark window. Priority between an operator edge and the tick is reached by watching `tap_1hz_o` right after a clock edge and raising `advance_i` or `clock_clear_i` in that same cycle.

// File: rtl/sweep_autostart_sched.sv
module sweep_autostart_sched #(
  parameter int REF_DIV      = 100,
  parameter int TICK_DIV     = 100000,
  parameter int NUM_SWITCHES = 12,
  parameter int IDX_W        = (NUM_SWITCHES > 1) ? $clog2(NUM_SWITCHES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    advance_i,
  input  logic                    clock_clear_i,
  input  logic                    sweep_end_i,
  input  logic [NUM_SWITCHES-1:0] prog_sw_i,
  output logic                    tap_100k_o,
  output logic                    tap_1hz_o,
  output logic [15:0]             clock_bcd_o,
  output logic [IDX_W-1:0]        scan_idx_o,
  output logic                    request_o,
  output logic                    autostart_o
);
  localparam int D1W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam int D2W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [D1W-1:0] div1;
  logic [D2W-1:0] div2;
  logic [3:0] su, st, mu, mt, nsu, nst, nmu, nmt;
  logic adv_q, clr_q, adv_p, clr_p, seg, hit;

  assign tap_100k_o = (div1 == D1W'(REF_DIV - 1));
  assign tap_1hz_o  = tap_100k_o && (div2 == D2W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div1 <= '0;
      div2 <= '0;
    end else begin
      div1 <= tap_100k_o ? '0 : div1 + 1'b1;
      if (tap_100k_o) div2 <= tap_1hz_o ? '0 : div2 + 1'b1;
    end
  end

  assign adv_p = advance_i && !adv_q;
  assign clr_p = clock_clear_i && !clr_q;

  always_comb begin
    nsu = su; nst = st; nmu = mu; nmt = mt;
    if (clr_p) begin
      nsu = 4'd0; nst = 4'd0; nmu = 4'd0; nmt = 4'd0;
    end else if (adv_p) begin
      nmu = (mu == 4'd0) ? 4'd9 : mu - 4'd1;
      if (mu == 4'd0) nmt = (mt == 4'd0) ? 4'd5 : mt - 4'd1;
    end else if (tap_1hz_o) begin
      nsu = (su == 4'd0) ? 4'd9 : su - 4'd1;
      if (su == 4'd0) begin
        nst = (st == 4'd0) ? 4'd5 : st - 4'd1;
        if (st == 4'd0) begin
          nmu = (mu == 4'd0) ? 4'd9 : mu - 4'd1;
          if (mu == 4'd0) nmt = (mt == 4'd0) ? 4'd5 : mt - 4'd1;
        end
      end
    end
  end

  assign seg = tap_1hz_o && !clr_p && !adv_p && nsu == 4'd0 && nst == 4'd0 &&
               (nmu == 4'd0 || nmu == 4'd5);
  assign hit = seg && prog_sw_i[scan_idx_o];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {mt, mu, st, su} <= '0;
      adv_q       <= 1'b0;
      clr_q       <= 1'b0;
      scan_idx_o  <= '0;
      request_o   <= 1'b0;
      autostart_o <= 1'b0;
    end else begin
      {mt, mu, st, su} <= {nmt, nmu, nst, nsu};
      adv_q       <= advance_i;
      clr_q       <= clock_clear_i;
      autostart_o <= hit && !request_o && !sweep_end_i;
      if (sweep_end_i)  request_o <= 1'b0;
      else if (hit)     request_o <= 1'b1;
      if (seg) scan_idx_o <= (scan_idx_o == IDX_W'(NUM_SWITCHES - 1)) ? '0 : scan_idx_o + 1'b1;
    end
  end

  assign clock_bcd_o = {mt, mu, st, su};

  p_tap_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_1hz_o |-> tap_100k_o);
  p_tap_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (REF_DIV > 1 && tap_100k_o) |=> !tap_100k_o);
  p_digit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    su <= 4'd9 && st <= 4'd5 && mu <= 4'd9 && mt <= 4'd5);
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clock_clear_i && !clr_q) |=> clock_bcd_o == 16'h0000);
  p_auto_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    autostart_o |=> !autostart_o);
  p_auto_sets_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    autostart_o |-> request_o);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (request_o && !sweep_end_i) |=> request_o);
  p_req_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_end_i |=> (!request_o && !autostart_o));
  p_scan_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_idx_o <= IDX_W'(NUM_SWITCHES - 1));
endmodule

// File: tb/tb_sweep_autostart_sched.sv
`timescale 1ns/1ps
module tb_sweep_autostart_sched;
  localparam int REF_DIV = 2;
  localparam int TICK_DIV = 5;
  localparam int NSW = 4;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic advance_i = 1'b0, clock_clear_i = 1'b0, sweep_end_i = 1'b0;
  logic [NSW-1:0] prog_sw_i = '0;
  logic tap_100k_o, tap_1hz_o, request_o, autostart_o;
  logic [15:0] clock_bcd_o;
  logic [IW-1:0] scan_idx_o;

  sweep_autostart_sched #(.REF_DIV(REF_DIV), .TICK_DIV(TICK_DIV), .NUM_SWITCHES(NSW), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .advance_i(advance_i), .clock_clear_i(clock_clear_i),
    .sweep_end_i(sweep_end_i), .prog_sw_i(prog_sw_i), .tap_100k_o(tap_100k_o),
    .tap_1hz_o(tap_1hz_o), .clock_bcd_o(clock_bcd_o), .scan_idx_o(scan_idx_o),
    .request_o(request_o), .autostart_o(autostart_o));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 0;
  int m_cyc = 0, m_secs = 0, m_idx = 0;
  bit m_req = 0, m_auto = 0, m_advq = 0, m_clrq = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    bit e100, e1, advp, clrp, seg, hit;
    int mm, ss, ebcd;
    e100 = (m_cyc % REF_DIV) == REF_DIV - 1;
    e1 = e100 && ((m_cyc / REF_DIV) % TICK_DIV) == TICK_DIV - 1;
    mm = m_secs / 60; ss = m_secs % 60;
    ebcd = ((mm / 10) << 12) | ((mm % 10) << 8) | ((ss / 10) << 4) | (ss % 10);
    if (!rst_n) chk(clock_bcd_o == 0 && scan_idx_o == 0 && !request_o && !autostart_o
                    && !tap_100k_o && !tap_1hz_o, "R10 reset state", clock_bcd_o, 0);
    chk(tap_100k_o == e100, "R1 100k tap", tap_100k_o, e100);
    chk(tap_1hz_o == e1, "R2 1Hz tap", tap_1hz_o, e1);
    chk(clock_bcd_o == ebcd[15:0], "R3/R4/R5 clock value", clock_bcd_o, ebcd);
    chk(scan_idx_o == m_idx, "R6 scan index", scan_idx_o, m_idx);
    chk(autostart_o == m_auto, "R7 autostart", autostart_o, m_auto);
    chk(request_o == m_req, "R8/R9 request", request_o, m_req);
    if (autostart_o) pulses++;
    if (!rst_n) begin
      m_cyc = 0; m_secs = 0; m_idx = 0; m_req = 0; m_auto = 0; m_advq = 0; m_clrq = 0;
    end else begin
      advp = advance_i && !m_advq;
      clrp = clock_clear_i && !m_clrq;
      seg = 0;
      if (clrp) m_secs = 0;
      else if (advp) m_secs = (m_secs + 3600 - 60) % 3600;
      else if (e1) begin
        m_secs = (m_secs + 3599) % 3600;
        seg = (m_secs % 300) == 0;
      end
      hit = seg && prog_sw_i[m_idx];
      m_auto = hit && !m_req && !sweep_end_i;
      if (sweep_end_i) m_req = 0;
      else if (hit) m_req = 1;
      if (seg) m_idx = (m_idx + 1) % NSW;
      m_advq = advance_i;
      m_clrq = clock_clear_i;
      m_cyc++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_in(input int which);
    if (which == 0) advance_i = 1; else if (which == 1) clock_clear_i = 1; else sweep_end_i = 1;
    wait_cyc(1);
    advance_i = 0; clock_clear_i = 0; sweep_end_i = 0;
    wait_cyc(2);
  endtask

  task automatic on_tick(input bit adv, input bit clr);
    do wait_cyc(1); while (!tap_1hz_o);
    advance_i = adv; clock_clear_i = clr;
    wait_cyc(1);
    advance_i = 0; clock_clear_i = 0;
    wait_cyc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    wait_cyc(4);
    rst_n = 1;
    prog_sw_i = 4'b1011;
    wait_cyc(3050);          // mark 1, switch 0 on: pulse (R7)
    wait_cyc(3000);          // mark 2, switch 1 on, request held: no pulse (R8)
    pulse_in(2);             // end of sweep (R9)
    wait_cyc(3000);          // mark 3, switch 2 off
    wait_cyc(3000);          // mark 4, switch 3 on: pulse
    pulse_in(2);
    wait_cyc(2900);
    sweep_end_i = 1;         // mark 5 while end of sweep high (R9)
    wait_cyc(200);
    sweep_end_i = 0;
    wait_cyc(2);
    pulse_in(0); pulse_in(0); // R4 advance
    advance_i = 1; wait_cyc(20); advance_i = 0; wait_cyc(2); // held level (R5)
    on_tick(1, 0);           // advance beats tick (R5)
    on_tick(1, 1);           // clear beats advance (R5)
    on_tick(0, 1);           // clear beats tick
    pulse_in(0);             // 00 -> 59 minutes (R4)
    clock_clear_i = 1; wait_cyc(30); clock_clear_i = 0; wait_cyc(2);
    wait_cyc(3100);          // mark after clear, scan wrap (R6)
    chk(pulses == 3, "R7 pulse count", pulses, 3);
    finish_run();
  end
endmodule